// File: doc/BRIEF.md
# Relock and Trusted-Time Sequencer

This block supervises a timing node as its network link comes and goes. It watches the link status, the frequency-lock indication from the oscillator discipline loop, a flag that says the delay and asymmetry coefficients have been loaded, and a flag that says the measurement window has stabilised. From these inputs it decides whether the node is free-running, riding its local clock in holdover, working back towards lock, or allowed to declare its time as trusted.

Recovery follows a fixed order. First the link must stay up for a programmable number of cycles, so that a flapping link does not restart the sequence. Then frequency lock must be reached, then coefficient loading, then window stability. After that a programmable settling interval must pass with all conditions still true. If a condition drops, the sequencer falls back to the earliest stage that is no longer met, and any settling progress is discarded. Loss of the link sends it to holdover and withdraws the trusted flag at once.

Every change of state produces a one-cycle event record holding the previous state, the new state and a cycle stamp. A downstream logger can store these records as event-aligned evidence.

Top module: `relock_trust_ctrl`

## Requirements
- R1: While reset is high and on release, state is FREERUN, trusted and holdover are low and no event is emitted. State codes on the state, evt_old and evt_new ports: FREERUN=0, HOLDOVER=1, ACQUIRE_FREQ=2, WAIT_COEFF=3, WAIT_WINDOW=4, SETTLE=5, TRUSTED=6.
- R2: From FREERUN or HOLDOVER the state moves to ACQUIRE_FREQ only after link_up has been sampled high on D consecutive clock edges, where D = max(cfg_debounce,1). The move happens at the edge that samples the D-th high. Any low sample restarts the count. With link_up low, FREERUN stays in FREERUN.
- R3: With link_up low in ACQUIRE_FREQ, WAIT_COEFF, WAIT_WINDOW, SETTLE or TRUSTED, the next edge enters HOLDOVER and clears trusted at that same edge. The holdover output is high exactly while the state is HOLDOVER.
- R4: Stages advance in order, one edge per stage:
  - ACQUIRE_FREQ goes to WAIT_COEFF when freq_locked is high.
  - WAIT_COEFF goes to WAIT_WINDOW when coeff_applied is high.
  - WAIT_WINDOW goes to SETTLE when window_stable is high.
  - Later gates raised early have no effect while an earlier gate is still low.
- R5: SETTLE lasts exactly S = max(cfg_settle,1) cycles with all gates high, then TRUSTED follows. With all gates already high, TRUSTED is first seen D+3+S edges after link_up rises in a waiting state.
- R6: If a gate drops in WAIT_COEFF, WAIT_WINDOW, SETTLE or TRUSTED (link still up), the next edge enters the earliest unmet stage. A low freq_locked gives ACQUIRE_FREQ, else a low coeff_applied gives WAIT_COEFF, else WAIT_WINDOW. A later entry into SETTLE restarts the full S-cycle count.
- R7: trusted is high exactly while the state is TRUSTED, rises only from SETTLE, and falls one edge after any gate or link_up is sampled low.
- R8: Each state change produces evt_valid for one cycle, in the same cycle the new state appears, with evt_old = previous state and evt_new = new state. evt_time holds the cycle count of the deciding cycle, counted from 0 in the first cycle after reset, so it equals the number of edges since reset release minus one.
- R9: evt_valid stays low in every cycle in which the state did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link status |
| freq_locked | input | 1 | Frequency loop reports lock |
| coeff_applied | input | 1 | Calibration coefficients loaded |
| window_stable | input | 1 | Measurement window stabilised |
| cfg_debounce | input | CNT_W | Consecutive link-up cycles needed (0 acts as 1) |
| cfg_settle | input | CNT_W | Settling cycles before trust (0 acts as 1) |
| state | output | 3 | Current state code |
| trusted | output | 1 | Time may be trusted |
| holdover | output | 1 | Node is in holdover |
| evt_valid | output | 1 | Event record strobe |
| evt_old | output | 3 | State before the transition |
| evt_new | output | 3 | State after the transition |
| evt_time | output | TS_W | Cycle stamp of the transition |

## Verification
The bound checker watches the following on every cycle:
- link loss forcing holdover with trust withdrawn;
- holdover persisting while the link is down;
- SETTLE being entered only from WAIT_WINDOW, and trust only from SETTLE;
- trust dropping after any gate falls;
- each state change matching exactly one event record carrying the right state pair.

The bench scenarios cover what needs counted time:
- exact debounce and settling durations swept over small configuration values;
- restart of the debounce count by a link flap;
- restart of settling after a mid-window gate drop;
- absolute values of the event cycle stamps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    ST_FREERUN     = 3'd0,
    ST_HOLDOVER    = 3'd1,
    ST_ACQ_FREQ    = 3'd2,
    ST_WAIT_COEFF  = 3'd3,
    ST_WAIT_WINDOW = 3'd4,
    ST_SETTLE      = 3'd5,
    ST_TRUSTED     = 3'd6
  } trust_state_t;

  typedef struct packed {
    logic freq;
    logic coeff;
    logic window;
  } gate_set_t;

  // Stage to fall back to when at least one gate is low (R6)
  function automatic trust_state_t earliest_unmet(gate_set_t g);
    if (!g.freq)       return ST_ACQ_FREQ;
    else if (!g.coeff) return ST_WAIT_COEFF;
    else               return ST_WAIT_WINDOW;
  endfunction

  function automatic logic all_met(gate_set_t g);
    return g.freq & g.coeff & g.window;
  endfunction

  function automatic logic is_waiting(trust_state_t s);
    return (s == ST_FREERUN) || (s == ST_HOLDOVER);
  endfunction

endpackage

// File: rtl/rtc_run_counter.sv
// Counts consecutive cycles with run high; done once the limit is met.
module rtc_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] goal;

  always_comb begin
    goal = (limit == '0) ? CNT_W'(1) : limit;
    done = run && (cnt_q >= (goal - CNT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_event_log.sv
// Free-running cycle stamp and one-cycle transition record.
module rtc_event_log
  import rtc_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  trust_state_t cur,
  input  trust_state_t nxt,
  output logic         evt_valid,
  output trust_state_t evt_old,
  output trust_state_t evt_new,
  output logic [TS_W-1:0] evt_time
);
  logic [TS_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q   <= '0;
      evt_valid <= 1'b0;
      evt_old   <= ST_FREERUN;
      evt_new   <= ST_FREERUN;
      evt_time  <= '0;
    end else begin
      stamp_q   <= stamp_q + TS_W'(1);
      evt_valid <= (nxt != cur);
      if (nxt != cur) begin
        evt_old  <= cur;
        evt_new  <= nxt;
        evt_time <= stamp_q;
      end
    end
  end
endmodule

// File: rtl/relock_trust_ctrl.sv
module relock_trust_ctrl
  import rtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             freq_locked,
  input  logic             coeff_applied,
  input  logic             window_stable,
  input  logic [CNT_W-1:0] cfg_debounce,
  input  logic [CNT_W-1:0] cfg_settle,
  output logic [2:0]       state,
  output logic             trusted,
  output logic             holdover,
  output logic             evt_valid,
  output logic [2:0]       evt_old,
  output logic [2:0]       evt_new,
  output logic [TS_W-1:0]  evt_time
);
  trust_state_t cur_q, nxt;
  trust_state_t log_old, log_new;
  gate_set_t    gates;
  logic         deb_run, deb_done;
  logic         settle_run, settle_done;
  logic         trusted_q, holdover_q;

  always_comb begin
    gates.freq   = freq_locked;
    gates.coeff  = coeff_applied;
    gates.window = window_stable;
    deb_run      = is_waiting(cur_q) && link_up;
    settle_run   = (cur_q == ST_SETTLE) && link_up && all_met(gates);
  end

  rtc_run_counter #(.CNT_W(CNT_W)) u_debounce (
    .clk(clk), .rst(rst), .run(deb_run), .limit(cfg_debounce), .done(deb_done)
  );

  rtc_run_counter #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst(rst), .run(settle_run), .limit(cfg_settle), .done(settle_done)
  );

  // Next-state decision
  always_comb begin
    nxt = cur_q;
    case (cur_q)
      ST_FREERUN, ST_HOLDOVER: begin
        if (deb_done) nxt = ST_ACQ_FREQ;
      end
      ST_ACQ_FREQ: begin
        if (!link_up)         nxt = ST_HOLDOVER;
        else if (gates.freq)  nxt = ST_WAIT_COEFF;
      end
      ST_WAIT_COEFF: begin
        if (!link_up)         nxt = ST_HOLDOVER;
        else if (!gates.freq) nxt = earliest_unmet(gates);
        else if (gates.coeff) nxt = ST_WAIT_WINDOW;
      end
      ST_WAIT_WINDOW: begin
        if (!link_up)                      nxt = ST_HOLDOVER;
        else if (!gates.freq || !gates.coeff) nxt = earliest_unmet(gates);
        else if (gates.window)             nxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (!link_up)              nxt = ST_HOLDOVER;
        else if (!all_met(gates))  nxt = earliest_unmet(gates);
        else if (settle_done)      nxt = ST_TRUSTED;
      end
      ST_TRUSTED: begin
        if (!link_up)              nxt = ST_HOLDOVER;
        else if (!all_met(gates))  nxt = earliest_unmet(gates);
      end
      default: nxt = ST_FREERUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= ST_FREERUN;
      trusted_q  <= 1'b0;
      holdover_q <= 1'b0;
    end else begin
      cur_q      <= nxt;
      trusted_q  <= (nxt == ST_TRUSTED);
      holdover_q <= (nxt == ST_HOLDOVER);
    end
  end

  rtc_event_log #(.TS_W(TS_W)) u_log (
    .clk(clk), .rst(rst), .cur(cur_q), .nxt(nxt),
    .evt_valid(evt_valid), .evt_old(log_old), .evt_new(log_new),
    .evt_time(evt_time)
  );

  assign state    = cur_q;
  assign trusted  = trusted_q;
  assign holdover = holdover_q;
  assign evt_old  = log_old;
  assign evt_new  = log_new;
endmodule

// File: rtl/relock_trust_ctrl_sva.sv
module relock_trust_ctrl_sva (
  input logic       clk,
  input logic       rst,
  input logic       link_up,
  input logic       freq_locked,
  input logic       coeff_applied,
  input logic       window_stable,
  input logic [2:0] state,
  input logic       trusted,
  input logic       holdover,
  input logic       evt_valid,
  input logic [2:0] evt_old,
  input logic [2:0] evt_new
);
  localparam logic [2:0] FR = 3'd0, HO = 3'd1, AQ = 3'd2, WC = 3'd3,
                         WW = 3'd4, SE = 3'd5, TR = 3'd6;

  p_freerun_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == FR && !link_up) |=> (state == FR));

  p_holdover_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == HO && !link_up) |=> (state == HO));

  p_link_loss_r3: assert property (@(posedge clk) disable iff (rst)
    (state != FR && state != HO && !link_up) |=> (state == HO && !trusted));

  p_holdover_flag_r3: assert property (@(posedge clk) disable iff (rst)
    holdover == (state == HO));

  p_settle_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SE && $past(state) != SE) |-> ($past(state) == WW));

  p_trust_from_settle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(trusted) |-> ($past(state) == SE));

  p_trust_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (trusted && !(link_up && freq_locked && coeff_applied && window_stable)) |=> !trusted);

  p_trust_state_r7: assert property (@(posedge clk) disable iff (rst)
    trusted == (state == TR));

  p_event_record_r8: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> (evt_valid && evt_new == state && evt_old == $past(state)));

  p_no_event_r9: assert property (@(posedge clk) disable iff (rst)
    (state == $past(state)) |-> !evt_valid);
endmodule

bind relock_trust_ctrl relock_trust_ctrl_sva u_sva (
  .clk(clk), .rst(rst), .link_up(link_up), .freq_locked(freq_locked),
  .coeff_applied(coeff_applied), .window_stable(window_stable),
  .state(state), .trusted(trusted), .holdover(holdover),
  .evt_valid(evt_valid), .evt_old(evt_old), .evt_new(evt_new)
);

// File: tb/relock_trust_ctrl_test.sv
`timescale 1ns/1ps
module relock_trust_ctrl_test;
  localparam int CNT_W = 16;
  localparam int TS_W  = 32;
  localparam int S_FR = 0, S_HO = 1, S_AQ = 2, S_WC = 3, S_WW = 4, S_SE = 5, S_TR = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0, freq_locked = 1'b0, coeff_applied = 1'b0, window_stable = 1'b0;
  logic [CNT_W-1:0] cfg_debounce = 16'd3, cfg_settle = 16'd2;
  logic [2:0] state, evt_old, evt_new;
  logic trusted, holdover, evt_valid;
  logic [TS_W-1:0] evt_time;

  int checks = 0, fails = 0, now = 0;
  logic [2:0] prev_state = 3'd0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  relock_trust_ctrl #(.CNT_W(CNT_W), .TS_W(TS_W)) uut (
    .clk(clk), .rst(rst), .link_up(link_up), .freq_locked(freq_locked),
    .coeff_applied(coeff_applied), .window_stable(window_stable),
    .cfg_debounce(cfg_debounce), .cfg_settle(cfg_settle),
    .state(state), .trusted(trusted), .holdover(holdover),
    .evt_valid(evt_valid), .evt_old(evt_old), .evt_new(evt_new), .evt_time(evt_time)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic gates(input bit f, input bit c, input bit w);
    freq_locked = f; coeff_applied = c; window_stable = w;
  endtask

  // Edge counter since reset release
  always @(posedge clk) begin
    if (rst) now <= 0;
    else     now <= now + 1;
  end

  // Event record monitor: R8 and R9
  always @(negedge clk) begin
    if (!rst) begin
      if (state != prev_state) begin
        check_eq("R8 evt_valid on change", int'(evt_valid), 1);
        check_eq("R8 evt_old", int'(evt_old), int'(prev_state));
        check_eq("R8 evt_new", int'(evt_new), int'(state));
        check_eq("R8 stamp", int'(evt_time), now - 1);
      end else begin
        check_eq("R9 no event without change", int'(evt_valid), 0);
      end
      check_eq("R7 trusted tracks TRUSTED", int'(trusted), int'(state == 3'(S_TR)));
      check_eq("R3 holdover tracks HOLDOVER", int'(holdover), int'(state == 3'(S_HO)));
    end
    prev_state = state;
  end

  // From a waiting state with link low and all gates high, measure time to trust
  task automatic run_to_trust(input int deb, input int stl);
    int got = 0;
    int d = (deb == 0) ? 1 : deb;
    int s = (stl == 0) ? 1 : stl;
    cfg_debounce = CNT_W'(deb);
    cfg_settle   = CNT_W'(stl);
    link_up = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      tick();
      if (state == 3'(S_TR)) begin got = k; break; end
    end
    check_eq($sformatf("R2 R5 edges to trust deb=%0d settle=%0d", deb, stl), got, d + 3 + s);
    link_up = 1'b0;
    tick();
    check_eq("R3 link loss from TRUSTED", int'(state), S_HO);
    check_eq("R3 trusted cleared on loss", int'(trusted), 0);
  endtask

  initial begin
    #(10 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    tick(4);
    check_eq("R1 reset state", int'(state), S_FR);
    check_eq("R1 reset trusted", int'(trusted), 0);
    check_eq("R1 reset holdover", int'(holdover), 0);
    check_eq("R1 reset evt_valid", int'(evt_valid), 0);
    rst = 1'b0;
    gates(1, 1, 1);
    tick(5);
    check_eq("R2 FREERUN stays with link low", int'(state), S_FR);

    // Sweep debounce and settle lengths
    for (int deb = 0; deb <= 4; deb++)
      for (int stl = 0; stl <= 5; stl++)
        run_to_trust(deb, stl);

    // Flap suppression with debounce 4, gates low
    cfg_debounce = 16'd4; cfg_settle = 16'd4;
    gates(0, 0, 0);
    link_up = 1'b1; tick(3);
    check_eq("R2 three highs not enough", int'(state), S_HO);
    link_up = 1'b0; tick();
    link_up = 1'b1; tick(3);
    check_eq("R2 flap restarted count", int'(state), S_HO);
    link_up = 1'b0; tick();
    link_up = 1'b1; tick(3);
    check_eq("R2 still holding", int'(state), S_HO);
    tick();
    check_eq("R2 fourth high leaves holdover", int'(state), S_AQ);

    // Ordered progression
    tick(3);
    check_eq("R4 waits for freq", int'(state), S_AQ);
    gates(0, 0, 1); tick(2);
    check_eq("R4 window alone ignored", int'(state), S_AQ);
    gates(0, 1, 1); tick(2);
    check_eq("R4 coeff without freq ignored", int'(state), S_AQ);
    gates(1, 1, 1); tick();
    check_eq("R4 freq -> WAIT_COEFF", int'(state), S_WC);
    tick();
    check_eq("R4 coeff -> WAIT_WINDOW", int'(state), S_WW);
    tick();
    check_eq("R4 window -> SETTLE", int'(state), S_SE);
    tick(3);
    check_eq("R5 still settling after 3", int'(state), S_SE);
    tick();
    check_eq("R5 trusted after 4", int'(state), S_TR);

    // Earliest unmet stage and settle restart
    gates(1, 0, 1); tick();
    check_eq("R6 coeff drop -> WAIT_COEFF", int'(state), S_WC);
    check_eq("R7 trust dropped", int'(trusted), 0);
    tick();
    check_eq("R6 stays WAIT_COEFF", int'(state), S_WC);
    gates(1, 1, 1); tick(2);
    check_eq("R6 back in SETTLE", int'(state), S_SE);
    tick(2);
    gates(1, 1, 0); tick();
    check_eq("R6 window drop in SETTLE", int'(state), S_WW);
    gates(1, 1, 1); tick();
    check_eq("R6 re-enter SETTLE", int'(state), S_SE);
    tick(3);
    check_eq("R6 settle restarted from zero", int'(state), S_SE);
    tick();
    check_eq("R6 trusted after full settle", int'(state), S_TR);
    gates(0, 0, 1); tick();
    check_eq("R6 freq+coeff drop -> ACQUIRE_FREQ", int'(state), S_AQ);
    gates(1, 0, 1); tick();
    check_eq("R6 partial recovery WAIT_COEFF", int'(state), S_WC);
    gates(1, 1, 1); tick(2);
    check_eq("R6 SETTLE again", int'(state), S_SE);
    gates(0, 1, 1); tick();
    check_eq("R6 freq drop in SETTLE", int'(state), S_AQ);
    gates(1, 1, 0); tick(2);
    check_eq("R6 reaches WAIT_WINDOW", int'(state), S_WW);
    tick();
    check_eq("R4 waits for window", int'(state), S_WW);
    gates(1, 0, 0); tick();
    check_eq("R6 coeff drop in WAIT_WINDOW", int'(state), S_WC);
    link_up = 1'b0; tick();
    check_eq("R3 link loss from WAIT_COEFF", int'(state), S_HO);

    // Link loss during SETTLE
    cfg_debounce = 16'd1;
    gates(1, 1, 1);
    link_up = 1'b1; tick(4);
    check_eq("R4 fast path to SETTLE", int'(state), S_SE);
    link_up = 1'b0; tick();
    check_eq("R3 link loss from SETTLE", int'(state), S_HO);
    check_eq("R3 holdover flag", int'(holdover), 1);
    link_up = 1'b1; tick();
    check_eq("R2 debounce 1 leaves holdover", int'(state), S_AQ);
    link_up = 1'b0; tick();
    check_eq("R3 link loss from ACQUIRE_FREQ", int'(state), S_HO);
    tick(2);
    finish_run();
  end
endmodule